// File: doc/BRIEF.md
# Buffered UART Transmitter with Flow Control

This block serialises characters onto an asynchronous serial line. A host writes a character into a single holding slot. As soon as the shift stage is free, the character moves into it, and the slot can take the next character while the current frame is still going out. A frame is a low start bit, then 7, 8 or 9 data bits sent least significant bit first, then an optional even or odd parity bit, then one or two high stop bits. The bit period comes from a divider that counts 16 × (n + 1) pulses of a count-enable strobe. The divider value n is supplied on an input port.

Clear-to-send flow control is optional. When it is enabled, the line input is looked at only at frame boundaries. A frame already on the wire always completes. The next frame waits, with the line held high, until the input goes low, and then it starts without delay. Clearing the transmit enable also lets the current frame finish and blocks further frames. Two flags report an empty holding slot and an idle shift stage. An interrupt request is raised by one of these two events, picked by a select input, and it stays set until it is acknowledged.

Top module: `uart_tx_buf`

## Requirements
- R1: One bit period lasts 16 × (div_i + 1) cycles in which cnt_en_i is high. The divider and the 16-step counter restart at the first bit of every frame that follows an idle period.
- R2: A frame is a 0 start bit, then the data bits LSB first, then the parity bit if par_en_i=1, then stop bits at 1. The data width is set by data_len_i: 0 selects 7 bits, 1 or 3 selects 8 bits, 2 selects 9 bits. two_stop_i=1 gives two stop bits and 0 gives one.
- R3: Parity is computed over the selected data bits only. With par_odd_i=0 the data bits plus the parity bit hold an even number of ones. With par_odd_i=1 they hold an odd number.
- R4: A write with wr_i=1 clears buf_empty_o on the next cycle. The move of the held character into a free shift stage sets buf_empty_o to 1.
- R5: sr_empty_o is 0 for the whole frame. It returns to 1 when the last stop bit ends and no following frame starts. txd_o is 1 whenever no frame is being sent.
- R6: If a character is already waiting when a frame's last stop bit ends, the next start bit follows immediately, with no idle bit time between the two frames.
- R7: With cts_en_i=1, a frame starts only while cts_ni=0. A rise of cts_ni during a frame does not cut that frame short. A waiting character is held back, with txd_o high, until cts_ni falls, and then it starts within two cycles.
- R8: With tx_en_i=0, no frame starts and the bit divider does not run. A frame already in progress completes.
- R9: With irq_sel_i=0, irq_o is set when the held character moves into the shift stage. With irq_sel_i=1, irq_o is set only when sr_empty_o rises.
- R10: Once set, irq_o stays 1 until a cycle with irq_ack_i=1 clears it.
- R11: After reset, txd_o=1, buf_empty_o=1, sr_empty_o=1 and irq_o=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cnt_en_i | input | 1 | Count-source strobe for the bit divider |
| div_i | input | 8 | Divider value n |
| tx_en_i | input | 1 | Transmit enable |
| data_len_i | input | 2 | Data width select (0: 7, 1 or 3: 8, 2: 9) |
| par_en_i | input | 1 | Parity bit enable |
| par_odd_i | input | 1 | 1 selects odd parity, 0 selects even |
| two_stop_i | input | 1 | 1 selects two stop bits |
| cts_en_i | input | 1 | Clear-to-send gating enable |
| cts_ni | input | 1 | Clear-to-send input, active low |
| irq_sel_i | input | 1 | Interrupt cause: 0 buffer empty, 1 shift stage empty |
| wr_i | input | 1 | Holding-slot write strobe |
| wr_data_i | input | 9 | Character to send |
| irq_ack_i | input | 1 | Clears the interrupt request |
| txd_o | output | 1 | Serial data line |
| buf_empty_o | output | 1 | Holding slot empty |
| sr_empty_o | output | 1 | Shift stage idle |
| irq_o | output | 1 | Interrupt request |

## Verification
Some properties are checked on every cycle. A write always fills the slot. An emptying slot always coincides with a busy shift stage. Every frame opens with a low line. No frame starts while the transmit enable is clear or the clear-to-send input is high. A pending interrupt survives until it is acknowledged. Other behaviour can only be shown by the bench's scenarios, which decode whole frames from the line: the exact bit order and parity for each format, the bit period for a given divider value, the absence of a gap between back-to-back frames, and the completion of a frame after flow control or the enable withdraws permission.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;
  localparam int unsigned MAX_DATA_W = 9;
  localparam int unsigned FRAME_W    = 1 + MAX_DATA_W + 1 + 2;
  localparam int unsigned BIT_CNT_W  = $clog2(FRAME_W + 1);

  typedef enum logic [1:0] {
    LEN_7  = 2'd0,
    LEN_8  = 2'd1,
    LEN_9  = 2'd2,
    LEN_8B = 2'd3
  } data_len_e;

  typedef struct packed {
    data_len_e len;
    logic      par_en;
    logic      par_odd;
    logic      two_stop;
  } frame_cfg_t;
endpackage

// File: rtl/uart_tx_baud.sv
module uart_tx_baud #(
  parameter int unsigned DIV_W = 8,
  parameter int unsigned OS    = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             cnt_en_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             bit_end_o
);
  localparam int unsigned OS_W = $clog2(OS);

  logic [DIV_W-1:0] div_q;
  logic [OS_W-1:0]  os_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q <= '0;
      os_q  <= OS_W'(OS - 1);
    end else if (!run_i) begin
      div_q <= div_i;
      os_q  <= OS_W'(OS - 1);
    end else if (cnt_en_i) begin
      if (div_q == '0) begin
        div_q <= div_i;
        os_q  <= (os_q == '0) ? OS_W'(OS - 1) : os_q - 1'b1;
      end else begin
        div_q <= div_q - 1'b1;
      end
    end
  end

  assign bit_end_o = run_i & cnt_en_i & (div_q == '0) & (os_q == '0);
endmodule

// File: rtl/uart_tx_hold.sv
module uart_tx_hold #(
  parameter int unsigned W = 9
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_i,
  input  logic [W-1:0] wr_data_i,
  input  logic         take_i,
  output logic [W-1:0] data_o,
  output logic         full_o
);
  logic [W-1:0] data_q;
  logic         full_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= '0;
      full_q <= 1'b0;
    end else begin
      if (wr_i) data_q <= wr_data_i;
      if (wr_i) full_q <= 1'b1;
      else if (take_i) full_q <= 1'b0;
    end
  end

  assign data_o = data_q;
  assign full_o = full_q;
endmodule

// File: rtl/uart_tx_frame.sv
module uart_tx_frame
  import uart_tx_pkg::*;
(
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  frame_cfg_t            cfg_i,
  input  logic                  start_ok_i,
  input  logic                  pend_i,
  input  logic [MAX_DATA_W-1:0] data_i,
  input  logic                  bit_end_i,
  output logic                  take_o,
  output logic                  busy_o,
  output logic                  done_o,
  output logic                  txd_o
);
  logic [FRAME_W-1:0]    shift_q, img, d_ext;
  logic [BIT_CNT_W-1:0]  left_q, nbits;
  logic                  busy_q, frame_end, par_bit;
  logic [3:0]            dlen;
  logic [MAX_DATA_W-1:0] dmask, dsel;

  always_comb begin
    case (cfg_i.len)
      LEN_7:   dlen = 4'd7;
      LEN_9:   dlen = 4'd9;
      default: dlen = 4'd8;
    endcase
    // shift of 1 by full width wraps to zero, so minus one yields all ones
    dmask   = (MAX_DATA_W'(1) << dlen) - 1'b1;
    dsel    = data_i & dmask;
    par_bit = (^dsel) ^ cfg_i.par_odd;
    d_ext   = FRAME_W'(dsel);
    img     = '1;
    img[0]  = 1'b0;
    for (int i = 1; i < FRAME_W; i++) begin
      if (i <= int'(dlen)) img[i] = d_ext[i-1];
      else if (cfg_i.par_en && i == int'(dlen) + 1) img[i] = par_bit;
    end
    nbits = BIT_CNT_W'(dlen) + BIT_CNT_W'(2) + BIT_CNT_W'(cfg_i.par_en)
          + BIT_CNT_W'(cfg_i.two_stop);
  end

  assign frame_end = busy_q & bit_end_i & (left_q == BIT_CNT_W'(1));
  assign take_o    = pend_i & start_ok_i & (~busy_q | frame_end);
  assign done_o    = frame_end & ~take_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shift_q <= '1;
      left_q  <= '0;
      busy_q  <= 1'b0;
    end else if (take_o) begin
      shift_q <= img;
      left_q  <= nbits;
      busy_q  <= 1'b1;
    end else if (frame_end) begin
      shift_q <= '1;
      left_q  <= '0;
      busy_q  <= 1'b0;
    end else if (busy_q && bit_end_i) begin
      shift_q <= {1'b1, shift_q[FRAME_W-1:1]};
      left_q  <= left_q - 1'b1;
    end
  end

  assign busy_o = busy_q;
  assign txd_o  = shift_q[0];
endmodule

// File: rtl/uart_tx_buf.sv
module uart_tx_buf
  import uart_tx_pkg::*;
#(
  parameter int unsigned DIV_W = 8
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  cnt_en_i,
  input  logic [DIV_W-1:0]      div_i,
  input  logic                  tx_en_i,
  input  logic [1:0]            data_len_i,
  input  logic                  par_en_i,
  input  logic                  par_odd_i,
  input  logic                  two_stop_i,
  input  logic                  cts_en_i,
  input  logic                  cts_ni,
  input  logic                  irq_sel_i,
  input  logic                  wr_i,
  input  logic [MAX_DATA_W-1:0] wr_data_i,
  input  logic                  irq_ack_i,
  output logic                  txd_o,
  output logic                  buf_empty_o,
  output logic                  sr_empty_o,
  output logic                  irq_o
);
  logic [MAX_DATA_W-1:0] hold_data;
  logic                  hold_full, take, busy, done, bit_end, start_ok, irq_q, irq_set;
  frame_cfg_t            cfg;

  assign cfg      = '{len: data_len_e'(data_len_i), par_en: par_en_i,
                      par_odd: par_odd_i, two_stop: two_stop_i};
  assign start_ok = tx_en_i & (~cts_en_i | ~cts_ni);

  uart_tx_hold #(.W(MAX_DATA_W)) u_hold (
    .clk_i, .rst_ni, .wr_i, .wr_data_i,
    .take_i(take), .data_o(hold_data), .full_o(hold_full)
  );

  uart_tx_baud #(.DIV_W(DIV_W), .OS(16)) u_baud (
    .clk_i, .rst_ni, .run_i(busy), .cnt_en_i, .div_i, .bit_end_o(bit_end)
  );

  uart_tx_frame u_frame (
    .clk_i, .rst_ni, .cfg_i(cfg), .start_ok_i(start_ok), .pend_i(hold_full),
    .data_i(hold_data), .bit_end_i(bit_end), .take_o(take), .busy_o(busy),
    .done_o(done), .txd_o
  );

  // a write in the same cycle as the transfer keeps the slot full
  assign irq_set = irq_sel_i ? done : (take & ~wr_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        irq_q <= 1'b0;
    else if (irq_set)   irq_q <= 1'b1;
    else if (irq_ack_i) irq_q <= 1'b0;
  end

  assign buf_empty_o = ~hold_full;
  assign sr_empty_o  = ~busy;
  assign irq_o       = irq_q;
endmodule

// File: rtl/uart_tx_buf_chk.sv
module uart_tx_buf_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       tx_en_i,
  input logic       cts_en_i,
  input logic       cts_ni,
  input logic       wr_i,
  input logic       irq_ack_i,
  input logic       txd_o,
  input logic       buf_empty_o,
  input logic       sr_empty_o,
  input logic       irq_o
);
  p_write_fills_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> !buf_empty_o);

  p_empty_on_transfer_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(buf_empty_o) |-> !sr_empty_o);

  p_frame_opens_low_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sr_empty_o) |-> !txd_o);

  p_no_start_disabled_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tx_en_i && sr_empty_o) |=> sr_empty_o);

  p_no_start_cts_high_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cts_en_i && cts_ni && sr_empty_o) |=> sr_empty_o);

  p_irq_sticky_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !irq_ack_i) |=> irq_o);
endmodule

bind uart_tx_buf uart_tx_buf_chk u_chk (.*);

// File: tb/uart_tx_buf_tb_top.sv
`timescale 1ns/1ps
module uart_tx_buf_tb_top;
  logic       clk_i = 1'b0, rst_ni = 1'b0;
  logic       cnt_en_i = 1'b1, tx_en_i = 1'b1;
  logic [7:0] div_i = 8'd0;
  logic [1:0] data_len_i = 2'd1;
  logic       par_en_i = 1'b0, par_odd_i = 1'b0, two_stop_i = 1'b0;
  logic       cts_en_i = 1'b0, cts_ni = 1'b1, irq_sel_i = 1'b0;
  logic       wr_i = 1'b0, irq_ack_i = 1'b0;
  logic [8:0] wr_data_i = '0;
  logic       txd_o, buf_empty_o, sr_empty_o, irq_o;

  int n_vec = 0, n_fail = 0, cyc = 0;
  bit done_run = 0;
  logic [31:0] cap;

  always #10 clk_i = ~clk_i;

  uart_tx_buf dut_i (.*);

  typedef struct packed {
    logic [1:0]  len;
    logic        pe;
    logic        po;
    logic        ts;
    logic [8:0]  data;
    logic [12:0] exp;
    logic [3:0]  nb;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VECS [NV] = '{
    '{2'd1, 1'b0, 1'b0, 1'b0, 9'h055, 13'h02AA, 4'd10},
    '{2'd1, 1'b1, 1'b0, 1'b0, 9'h00F, 13'h041E, 4'd11},
    '{2'd1, 1'b1, 1'b1, 1'b1, 9'h001, 13'h0C02, 4'd12},
    '{2'd0, 1'b1, 1'b0, 1'b0, 9'h1FF, 13'h03FE, 4'd10},
    '{2'd2, 1'b0, 1'b0, 1'b1, 9'h100, 13'h0E00, 4'd12},
    '{2'd2, 1'b1, 1'b1, 1'b0, 9'h1A5, 13'h0B4A, 4'd12},
    '{2'd0, 1'b0, 1'b0, 1'b1, 9'h000, 13'h0300, 4'd10}
  };

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  endtask

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
    n_vec++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic write(input logic [8:0] d);
    @(negedge clk_i);
    wr_i = 1'b1; wr_data_i = d;
    @(negedge clk_i);
    wr_i = 1'b0;
  endtask

  task automatic pulse_ack();
    @(negedge clk_i);
    irq_ack_i = 1'b1;
    @(negedge clk_i);
    irq_ack_i = 1'b0;
  endtask

  // waits for a start bit, then samples nbits at mid-bit into cap
  task automatic capture(input int nbits);
    int t = 0;
    int per = 16 * (int'(div_i) + 1);
    cap = '1;
    while (txd_o !== 1'b0 && t < 4000) begin
      @(negedge clk_i);
      t++;
    end
    wait_n(per / 2);
    for (int i = 0; i < nbits; i++) begin
      cap[i] = txd_o;
      if (i != nbits - 1) wait_n(per);
    end
  endtask

  function automatic logic [9:0] f8n1(input logic [7:0] d);
    return {1'b1, d, 1'b0};
  endfunction

  initial begin
    forever begin
      @(posedge clk_i);
      cyc++;
      if (cyc > 150000 && !done_run) begin
        n_fail++;
        $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
        summary();
      end
    end
  end

  initial begin
    wait_n(3);
    // R11: reset values
    chk({28'd0, txd_o, buf_empty_o, sr_empty_o, irq_o}, 32'hE, "R11 reset state");
    rst_ni = 1'b1;
    wait_n(2);

    // R2 R3 R5: frame formats from the table
    for (int v = 0; v < NV; v++) begin
      data_len_i = VECS[v].len; par_en_i = VECS[v].pe;
      par_odd_i  = VECS[v].po;  two_stop_i = VECS[v].ts;
      write(VECS[v].data);
      capture(int'(VECS[v].nb));
      chk(cap & ((32'd1 << VECS[v].nb) - 1), 32'(VECS[v].exp), "R2/R3 frame bits");
      wait_n(12);
      chk({30'd0, sr_empty_o, txd_o}, 32'h3, "R5 idle after frame");
    end
    data_len_i = 2'd1; par_en_i = 1'b0; par_odd_i = 1'b0; two_stop_i = 1'b0;

    // R1: divider n=2 gives 48-cycle bits
    div_i = 8'd2;
    write(9'h0FF);
    begin
      int lo = 0, t = 0;
      while (txd_o !== 1'b0 && t < 1000) begin @(negedge clk_i); t++; end
      while (txd_o === 1'b0 && lo < 1000) begin lo++; @(negedge clk_i); end
      chk(lo, 48, "R1 bit period n=2");
    end
    wait_n(600);
    div_i = 8'd0;

    // R4 R6: back-to-back frames
    write(9'h03C);
    chk({31'd0, buf_empty_o}, 32'd0, "R4 write clears empty");
    wait_n(3);
    chk({31'd0, buf_empty_o}, 32'd1, "R4 transfer sets empty");
    write(9'h0C3);
    chk({31'd0, buf_empty_o}, 32'd0, "R4 second write pending");
    cap = '0;
    capture(20);
    chk(cap & 32'hFFFFF, {12'd0, f8n1(8'hC3), f8n1(8'h3C)}, "R6 no gap between frames");
    wait_n(12);

    // R9 R10: buffer-empty cause and stickiness
    irq_sel_i = 1'b0;
    pulse_ack();
    chk({31'd0, irq_o}, 32'd0, "R10 ack clears");
    write(9'h0A5);
    wait_n(3);
    chk({31'd0, irq_o}, 32'd1, "R9 buffer cause");
    wait_n(60);
    chk({31'd0, irq_o}, 32'd1, "R10 held until ack");
    pulse_ack();
    chk({31'd0, irq_o}, 32'd0, "R10 cleared by ack");
    wait_n(200);

    // R9: shift-empty cause
    irq_sel_i = 1'b1;
    pulse_ack();
    write(9'h05A);
    wait_n(40);
    chk({31'd0, irq_o}, 32'd0, "R9 shift cause not yet");
    wait_n(160);
    chk({30'd0, irq_o, sr_empty_o}, 32'h3, "R9 shift cause at frame end");
    irq_sel_i = 1'b0;
    pulse_ack();

    // R7: flow control
    cts_en_i = 1'b1; cts_ni = 1'b1;
    write(9'h05A);
    wait_n(100);
    chk({29'd0, txd_o, sr_empty_o, buf_empty_o}, 32'h6, "R7 held while cts high");
    @(negedge clk_i); cts_ni = 1'b0;
    wait_n(2);
    chk({30'd0, txd_o, sr_empty_o}, 32'h0, "R7 starts when cts low");
    write(9'h081);
    wait_n(40);
    cts_ni = 1'b1;
    wait_n(55);
    chk({31'd0, sr_empty_o}, 32'd0, "R7 frame not aborted");
    wait_n(80);
    chk({29'd0, txd_o, sr_empty_o, buf_empty_o}, 32'h6, "R7 paused after frame");
    wait_n(100);
    chk({29'd0, txd_o, sr_empty_o, buf_empty_o}, 32'h6, "R7 still paused");
    @(negedge clk_i); cts_ni = 1'b0;
    capture(10);
    chk(cap & 32'h3FF, {22'd0, f8n1(8'h81)}, "R7 resumed frame");
    wait_n(12);
    cts_en_i = 1'b0; cts_ni = 1'b1;

    // R8: transmit enable
    tx_en_i = 1'b0;
    write(9'h011);
    wait_n(100);
    chk({29'd0, txd_o, sr_empty_o, buf_empty_o}, 32'h6, "R8 no start when disabled");
    tx_en_i = 1'b1;
    wait_n(3);
    chk({31'd0, sr_empty_o}, 32'd0, "R8 starts when enabled");
    write(9'h022);
    wait_n(20);
    tx_en_i = 1'b0;
    wait_n(100);
    chk({31'd0, sr_empty_o}, 32'd0, "R8 current frame completes");
    wait_n(100);
    chk({29'd0, txd_o, sr_empty_o, buf_empty_o}, 32'h6, "R8 next frame blocked");
    tx_en_i = 1'b1;
    capture(10);
    chk(cap & 32'h3FF, {22'd0, f8n1(8'h22)}, "R8 blocked frame sent later");
    wait_n(20);

    done_run = 1;
    summary();
  end
endmodule